// File: doc/BRIEF.md
# Multi-Source Hit Concentrator

This block gathers hit records from 32 readout sources on one detector module and sends them off the module over a narrow shared bus. Each record holds 10 data bits. Each source keeps its own small queue, so a record waits at its source until the concentrator picks it. A round-robin arbiter picks among the sources that have records waiting. The chosen record is tagged with the 5-bit number of its source and sent as two 8-bit beats. A busy line from the receiver stalls the bus.

A beat is transferred in every cycle where `bus_valid` is high and `bus_busy` is low. The head beat carries the source number in bits 7..3 and data bits 9..7 in bits 2..0. The tail beat carries 0 in bit 7, which marks it as a continuation, and data bits 6..0 in bits 6..0. If a record reaches a source whose queue is full, it is dropped, and a per-source saturating counter records the loss.

The sequencer has three states:
- `ST_IDLE` drives no beat.
- `ST_HEAD` presents the head beat.
- `ST_TAIL` presents the tail beat.

Its transitions are:
- IDLE to HEAD: a record is waiting and busy is low. The record is popped in this cycle.
- HEAD to HEAD: busy is high.
- HEAD to TAIL: busy is low.
- TAIL to TAIL: busy is high.
- TAIL to HEAD: busy is low and another record is waiting. That record is popped in this cycle.
- TAIL to IDLE: busy is low and nothing is waiting.

Top module: `hit_concentrator`

## Requirements
- R1: While reset is asserted and after it is released, `bus_valid` is 0 and every overflow counter reads 0.
- R2: The head beat is {source number[4:0], data[9:7]} and the tail beat is {1'b0, data[6:0]}.
- R3: A record's tail beat is presented in the cycle right after its head beat is accepted, with no other beat in between.
- R4: The arbiter searches the waiting sources starting one past the source it last granted, wrapping from 31 to 0. After reset the search starts at source 0.
- R5: While `bus_valid` and `bus_busy` are both high, the beat on the bus stays valid and unchanged in the next cycle.
- R6: If `bus_busy` is high while the bus is idle, no head beat starts in the next cycle.
- R7: Each source queues up to 4 records and sends them in the order they arrived.
- R8: A record that arrives while its source queue already holds 4 entries is dropped, even if an entry leaves in that same cycle. The source's 4-bit overflow counter then increases by 1 and stops at 15.
- R9: When a tail beat is accepted and another record is waiting, that record's head beat appears in the next cycle with no idle gap.
- R10: A record offered at a source before clock edge k can appear as a head beat no earlier than the cycle after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 32 | One strobe per source; a record is offered this cycle |
| hit_data | input | 320 | 10-bit record for each source; source i uses bits [10i+9:10i] |
| bus_busy | input | 1 | Receiver stall; a presented beat is not taken while this is high |
| bus_valid | output | 1 | A beat is presented on `bus_beat` |
| bus_beat | output | 8 | Head or tail beat of the current record |
| ovf_count | output | 128 | Saturating drop counter for each source; source i uses bits [4i+3:4i] |

## Verification
The bench follows every beat against its own model. A wrong queue pointer or count therefore shows up in the data or source field of the next record popped from that source. A wrong grant pointer shows up as a source number out of order in the next head beat. A sequencer that skips a stall or a state changes `bus_valid` or `bus_beat` within one cycle. A drop counter that counts wrongly is read directly at its port after each burst of overflows.

// File: rtl/hc_pkg.sv
package hc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_TAIL = 2'd2
    } ser_state_t;
endpackage

// File: rtl/hit_fifo.sv
module hit_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head_data,
    output logic          not_empty,
    output logic [CW-1:0] ovf_cnt
);
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PW-1:0]    wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;
    logic             full, do_push, do_pop, drop;

    assign full      = (cnt_q == CNT_W'(DEPTH));
    assign do_push   = push && !full;
    assign drop      = push && full;
    assign do_pop    = pop && (cnt_q != '0);
    assign not_empty = (cnt_q != '0);
    assign head_data = mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            cnt_q   <= '0;
            ovf_cnt <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
            if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
            if (drop && (ovf_cnt != '1)) ovf_cnt <= ovf_cnt + CW'(1);
        end
    end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic [IW-1:0] grant_idx,
    output logic          grant_any
);
    int cand;

    always_comb begin
        grant_any = 1'b0;
        grant_idx = last;
        cand      = 0;
        for (int k = 1; k <= N; k++) begin
            cand = (int'(last) + k) % N;
            if (!grant_any && req[cand]) begin
                grant_any = 1'b1;
                grant_idx = IW'(cand);
            end
        end
    end
endmodule

// File: rtl/hit_serializer.sv
module hit_serializer
    import hc_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 10,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_any,
    input  logic [AW-1:0] rec_src,
    input  logic [DW-1:0] rec_data,
    input  logic          bus_busy,
    output logic          load,
    output logic          bus_valid,
    output logic [BW-1:0] bus_beat,
    output ser_state_t    state
);
    localparam int HI_BITS = BW - AW;
    localparam int LO_BITS = BW - 1;

    ser_state_t    state_q, state_d;
    logic [AW-1:0] src_q;
    logic [DW-1:0] data_q;

    assign load  = !bus_busy && rec_any && (state_q != ST_HEAD);
    assign state = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            data_q <= '0;
        end else if (load) begin
            src_q  <= rec_src;
            data_q <= rec_data;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load)      state_d = ST_HEAD;
            ST_HEAD: if (!bus_busy) state_d = ST_TAIL;
            ST_TAIL: if (!bus_busy) state_d = load ? ST_HEAD : ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        bus_valid = 1'b0;
        bus_beat  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HEAD: begin
                bus_valid = 1'b1;
                bus_beat  = {src_q, data_q[DW-1 -: HI_BITS]};
            end
            ST_TAIL: begin
                bus_valid = 1'b1;
                bus_beat  = {1'b0, data_q[LO_BITS-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hit_concentrator.sv
module hit_concentrator #(
    parameter int NSRC   = 32,
    parameter int DATA_W = 10,
    parameter int DEPTH  = 4,
    parameter int OVF_W  = 4,
    parameter int BEAT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          hit_valid,
    input  logic [NSRC*DATA_W-1:0]   hit_data,
    input  logic                     bus_busy,
    output logic                     bus_valid,
    output logic [BEAT_W-1:0]        bus_beat,
    output logic [NSRC*OVF_W-1:0]    ovf_count
);
    localparam int SRC_W = $clog2(NSRC);

    logic [NSRC-1:0]   pending;
    logic [NSRC-1:0]   pop;
    logic [DATA_W-1:0] head_q [NSRC];
    logic [SRC_W-1:0]  grant_idx, last_q;
    logic              grant_any, load;
    hc_pkg::ser_state_t ser_state;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign pop[i] = load && (grant_idx == SRC_W'(i));
        hit_fifo #(.W(DATA_W), .DEPTH(DEPTH), .CW(OVF_W)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (hit_valid[i]),
            .push_data (hit_data[i*DATA_W +: DATA_W]),
            .pop       (pop[i]),
            .head_data (head_q[i]),
            .not_empty (pending[i]),
            .ovf_cnt   (ovf_count[i*OVF_W +: OVF_W])
        );
    end

    rr_arbiter #(.N(NSRC), .IW(SRC_W)) u_arb (
        .req       (pending),
        .last      (last_q),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    last_q <= SRC_W'(NSRC - 1);
        else if (load) last_q <= grant_idx;
    end

    hit_serializer #(.AW(SRC_W), .DW(DATA_W), .BW(BEAT_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_any   (grant_any),
        .rec_src   (grant_idx),
        .rec_data  (head_q[grant_idx]),
        .bus_busy  (bus_busy),
        .load      (load),
        .bus_valid (bus_valid),
        .bus_beat  (bus_beat),
        .state     (ser_state)
    );
endmodule

module hit_concentrator_chk #(
    parameter int NSRC   = 32,
    parameter int OVF_W  = 4,
    parameter int BEAT_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_busy,
    input logic                  bus_valid,
    input logic [BEAT_W-1:0]     bus_beat,
    input logic [NSRC-1:0]       pop,
    input logic [NSRC*OVF_W-1:0] ovf_count,
    input hc_pkg::ser_state_t    ser_state
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!bus_valid && (ovf_count == '0)));

    assert_tail_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_state == hc_pkg::ST_HEAD && !bus_busy) |=>
        (ser_state == hc_pkg::ST_TAIL && bus_valid && !bus_beat[BEAT_W-1]));

    assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_busy) |=> (bus_valid && $stable(bus_beat)));

    assert_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && bus_busy) |=> !bus_valid);

    assert_pop_to_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop != '0) |=> (ser_state == hc_pkg::ST_HEAD && bus_valid));

    for (genvar i = 0; i < NSRC; i++) begin : g_ovf
        assert_ovf_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_count[i*OVF_W +: OVF_W] >= $past(ovf_count[i*OVF_W +: OVF_W]));
    end
endmodule

bind hit_concentrator hit_concentrator_chk #(
    .NSRC(NSRC), .OVF_W(OVF_W), .BEAT_W(BEAT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_busy  (bus_busy),
    .bus_valid (bus_valid),
    .bus_beat  (bus_beat),
    .pop       (pop),
    .ovf_count (ovf_count),
    .ser_state (ser_state)
);

// File: tb/hit_concentrator_tb.sv
module hit_concentrator_tb;
    localparam int NSRC = 32;
    localparam int DW   = 10;
    localparam int OW   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:0]   hv = '0;
    logic [NSRC*DW-1:0] hd = '0;
    logic              busy = 1'b0;
    logic              bus_valid;
    logic [7:0]        bus_beat;
    logic [NSRC*OW-1:0] ovf_count;

    int checks = 0;
    int failures = 0;
    int cycle = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    hit_concentrator u_dut (
        .clk(clk), .rst_n(rst_n), .hit_valid(hv), .hit_data(hd),
        .bus_busy(busy), .bus_valid(bus_valid), .bus_beat(bus_beat),
        .ovf_count(ovf_count)
    );

    // behavioural reference: per-source queues, a phase and a grant pointer
    int m_q [NSRC][$];
    int m_ovf [NSRC];
    int m_phase;   // 0 idle, 1 head, 2 tail
    int m_src, m_data, m_last;

    always @(posedge clk) begin
        cycle++;
        if (!rst_n) begin
            m_phase = 0; m_last = NSRC - 1; m_src = 0; m_data = 0;
            for (int i = 0; i < NSRC; i++) begin m_q[i].delete(); m_ovf[i] = 0; end
        end else begin
            int sz [NSRC];
            int g;
            bit any, ld;
            for (int i = 0; i < NSRC; i++) sz[i] = m_q[i].size();
            any = 0; g = 0;
            for (int k = 1; k <= NSRC; k++) begin
                int idx;
                idx = (m_last + k) % NSRC;
                if (!any && sz[idx] > 0) begin any = 1; g = idx; end
            end
            ld = !busy && any && (m_phase != 1);
            case (m_phase)
                0: if (ld) m_phase = 1;
                1: if (!busy) m_phase = 2;
                default: if (!busy) m_phase = ld ? 1 : 0;
            endcase
            if (ld) begin
                m_data = m_q[g].pop_front();
                m_src = g; m_last = g;
            end
            for (int i = 0; i < NSRC; i++) begin
                if (hv[i]) begin
                    if (sz[i] >= 4) begin
                        if (m_ovf[i] < 15) m_ovf[i]++;
                    end else m_q[i].push_back(int'(hd[i*DW +: DW]));
                end
            end
        end
    end

    task automatic compare();
        logic ev;
        logic [7:0] eb;
        ev = (m_phase != 0);
        eb = (m_phase == 1) ? {m_src[4:0], m_data[9:7]} : {1'b0, m_data[6:0]};
        checks++;
        if (bus_valid !== ev || (ev && bus_beat !== eb)) begin
            failures++;
            $display("FAIL %s cycle %0d: valid=%0b beat=%02h expected valid=%0b beat=%02h",
                     cur_req, cycle, bus_valid, bus_beat, ev, eb);
        end
    endtask

    task automatic tick(input logic [NSRC-1:0] v, input logic b);
        hv = v; busy = b;
        @(posedge clk);
        @(negedge clk);
        compare();
        hv = '0;
    endtask

    task automatic set_data(input int s, input int d);
        hd[s*DW +: DW] = DW'(d);
    endtask

    task automatic check_ovf(input string req, input int s, input int exp);
        checks++;
        if (int'(ovf_count[s*OW +: OW]) != exp) begin
            failures++;
            $display("FAIL %s ovf source %0d: got %0d expected %0d",
                     req, s, ovf_count[s*OW +: OW], exp);
        end
    endtask

    task automatic drain(input int n);
        for (int c = 0; c < n; c++) tick('0, 1'b0);
    endtask

    initial begin
        // R1 reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        compare();
        for (int s = 0; s < NSRC; s += 8) check_ovf("R1", s, 0);
        rst_n = 1'b1;
        tick('0, 1'b0);

        // R2 / R10: single records, format and latency
        cur_req = "R2";
        set_data(5, 10'h2AB);
        tick(32'h1 << 5, 1'b0);
        drain(4);
        set_data(31, 10'h3FF);
        tick(32'h1 << 31, 1'b0);
        drain(4);
        cur_req = "R10";
        set_data(0, 10'h155);
        tick(32'h1, 1'b0);
        drain(4);

        // R4 / R9: every source at once, round-robin back-to-back drain
        cur_req = "R4";
        for (int s = 0; s < NSRC; s++) set_data(s, (s * 37 + 11) % 1024);
        tick('1, 1'b0);
        cur_req = "R9";
        drain(70);

        // R7: ordered queueing under stall
        cur_req = "R7";
        for (int r = 0; r < 4; r++) begin
            set_data(3, 100 + r);
            tick(32'h1 << 3, 1'b1);
        end
        drain(12);

        // R8: overflow, drop on full even with a pop, saturation
        cur_req = "R8";
        for (int r = 0; r < 6; r++) begin
            set_data(3, 200 + r);
            tick(32'h1 << 3, 1'b1);
        end
        check_ovf("R8", 3, 2);
        set_data(3, 300);
        tick(32'h1 << 3, 1'b0);   // pop happens this edge but queue was full
        check_ovf("R8", 3, 3);
        drain(14);
        for (int r = 0; r < 24; r++) begin
            set_data(7, r);
            tick(32'h1 << 7, 1'b1);
        end
        check_ovf("R8", 7, 15);
        check_ovf("R8", 3, 3);
        drain(12);

        // R5 / R6: random stalls with mixed traffic
        cur_req = "R5";
        for (int c = 0; c < 600; c++) begin
            logic [NSRC-1:0] v;
            v = '0;
            for (int s = 0; s < NSRC; s++) begin
                if ($urandom_range(0, 19) == 0) begin
                    v[s] = 1'b1;
                    set_data(s, int'($urandom_range(0, 1023)));
                end
            end
            tick(v, ($urandom_range(0, 2) == 0));
        end
        cur_req = "R6";
        for (int c = 0; c < 300; c++) tick('0, ($urandom_range(0, 1) == 0));
        drain(200);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule